// File: doc/BRIEF.md
# Bitwise three-input lookup unit

The unit evaluates any Boolean function of three inputs at every bit position of a 64-bit word. The function is an 8-entry truth table. Each bit position forms a 3-bit index from its three input bits and reads the result from the table. The table comes either from an immediate byte or from the low byte of a fourth operand. The previous destination value is always one of the three inputs, so the unit works as a read-modify-write on the destination.

Two further forms share the same table.

- **Lane form.** It takes its three inputs from three packed bytes of one operand. It builds an 8-bit pattern and writes that pattern into the 8-bit lanes picked by a 4-bit mask. The other bits keep the old destination value.
- **Whole-word form.** It reduces each operand to a single zero/nonzero flag and returns the looked-up bit as the integer 0 or 1.

Results are registered. There is one cycle of latency, qualified by a valid strobe.

Top module: `bitlut3_unit`

## Requirements
- R1: In immediate form (mode_i = 0), result bit i equals table_i[idx], where idx = {dest_i[i], ra_i[i], rb_i[i]}. dest_i is the most significant index bit and rb_i the least. Table bit 0 is the LSB of table_i.
- R2: In immediate form, table 8'hF0 returns dest_i unchanged. Table 8'hCA returns the bitwise select (dest_i ? ra_i : rb_i).
- R3: In register-table form (mode_i = 1), the index is formed as in R1. The result bit is rc_i[idx]. Bits 63..8 of rc_i have no effect.
- R4: In lane form (mode_i = 2), x = ra_i[7:0], y = ra_i[15:8] and z = ra_i[23:16]. The pattern bit k equals table_i[{x[k], y[k], z[k]}]. Lane j covers result bits 8j+7..8j, and an enabled lane receives the pattern.
- R5: In lane form, a lane j whose lane_mask_i[j] is 0 keeps dest_i. Result bits 63..32 always keep dest_i. Bits 63..24 of ra_i, and all of rb_i, have no effect.
- R6: In whole-word form (mode_i = 3), result_o equals table_i[{dest_i != 0, ra_i != 0, rb_i != 0}] as the integer 0 or 1. Bits 63..1 are zero.
- R7: valid_o is valid_i delayed by one clock. result_o shows the result of the operation presented with valid_i one clock earlier.
- R8: While valid_i is low, result_o holds its value whatever the other inputs do.
- R9: After reset, valid_o is 0 and result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 2 | 0 immediate, 1 register table, 2 lane, 3 whole word |
| ra_i | input | 64 | First data operand |
| rb_i | input | 64 | Second data operand |
| rc_i | input | 64 | Table operand for register-table form |
| dest_i | input | 64 | Previous destination value |
| table_i | input | 8 | Immediate truth table |
| lane_mask_i | input | 4 | Lane write enables for lane form |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Result word |

## Verification
The bench targets the index bit order, with one-hot tables and the 0xF0 and 0xCA identities. A design that swapped operands or read the table from the wrong end would return rb_i or a mirrored function.

In lane form it uses all-zero and all-one masks and sets garbage in ra_i above byte 2. A design that confused the x and z bytes, or wrote unmasked or upper lanes, would corrupt bits that must keep dest_i.

Register-table cases put noise in rc_i above bit 7. Whole-word cases use operands with a single far bit set. A design that reduced only the low byte, or left stale upper bits, would report the wrong flag.

Idle cycles with changing inputs check that the output register holds.

// File: rtl/lut3_pkg.sv
package lut3_pkg;
  typedef enum logic [1:0] {
    MODE_IMM  = 2'd0,
    MODE_REG  = 2'd1,
    MODE_LANE = 2'd2,
    MODE_BOOL = 2'd3
  } lut_mode_e;

  localparam int unsigned TBL_W = 8;
endpackage

// File: rtl/lut3_bitwise.sv
module lut3_bitwise #(
  parameter int unsigned W = 64
) (
  input  logic [7:0]   table_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign y_o[g] = table_i[{c_i[g], b_i[g], a_i[g]}];
  end
endmodule

// File: rtl/lut3_lane.sv
module lut3_lane #(
  parameter int unsigned W      = 64,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic [7:0]          table_i,
  input  logic [3*LANE_W-1:0] fields_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic [W-1:0]        dest_i,
  output logic [W-1:0]        y_o
);
  localparam int unsigned COVER = LANES * LANE_W;

  logic [LANE_W-1:0] pattern;

  // x (byte 0) drives the top index bit, z (byte 2) the bottom one
  lut3_bitwise #(.W(LANE_W)) u_pat (
    .table_i(table_i),
    .a_i    (fields_i[2*LANE_W +: LANE_W]),
    .b_i    (fields_i[LANE_W +: LANE_W]),
    .c_i    (fields_i[0 +: LANE_W]),
    .y_o    (pattern)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign y_o[j*LANE_W +: LANE_W] = mask_i[j] ? pattern : dest_i[j*LANE_W +: LANE_W];
  end

  if (COVER < W) begin : g_upper
    assign y_o[W-1:COVER] = dest_i[W-1:COVER];
  end
endmodule

// File: rtl/lut3_bool.sv
module lut3_bool #(
  parameter int unsigned W = 64
) (
  input  logic [7:0]   table_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  logic [2:0] idx;
  assign idx = {|c_i, |b_i, |a_i};
  assign y_o = {{(W-1){1'b0}}, table_i[idx]};
endmodule

// File: rtl/bitlut3_unit.sv
module bitlut3_unit
  import lut3_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] ra_i,
  input  logic [DATA_W-1:0] rb_i,
  input  logic [DATA_W-1:0] rc_i,
  input  logic [DATA_W-1:0] dest_i,
  input  logic [7:0]        table_i,
  input  logic [LANES-1:0]  lane_mask_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned FIELD_BITS = 3 * LANE_W;

  lut_mode_e         mode;
  logic [TBL_W-1:0]  bit_table;
  logic [DATA_W-1:0] bitwise_res, lane_res, bool_res, next_res;
  logic              unused_ok;

  assign mode      = lut_mode_e'(mode_i);
  assign bit_table = (mode == MODE_REG) ? rc_i[TBL_W-1:0] : table_i;
  assign unused_ok = ^{rc_i[DATA_W-1:TBL_W], ra_i[DATA_W-1:FIELD_BITS]};

  lut3_bitwise #(.W(DATA_W)) u_bitwise (
    .table_i(bit_table),
    .a_i    (rb_i),
    .b_i    (ra_i),
    .c_i    (dest_i),
    .y_o    (bitwise_res)
  );

  lut3_lane #(.W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_lane (
    .table_i (table_i),
    .fields_i(ra_i[FIELD_BITS-1:0]),
    .mask_i  (lane_mask_i),
    .dest_i  (dest_i),
    .y_o     (lane_res)
  );

  lut3_bool #(.W(DATA_W)) u_bool (
    .table_i(table_i),
    .a_i    (rb_i),
    .b_i    (ra_i),
    .c_i    (dest_i),
    .y_o    (bool_res)
  );

  always_comb begin
    unique case (mode)
      MODE_LANE: next_res = lane_res;
      MODE_BOOL: next_res = bool_res;
      default:   next_res = bitwise_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= next_res;
    end
  end

  a_r7_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r7_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r6_bool_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd3) |=> (result_o[DATA_W-1:1] == '0));
  a_r2_pass_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd0 && table_i == 8'hF0) |=> (result_o == $past(dest_i)));
  a_r5_upper_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == 2'd2) |=>
      (result_o[DATA_W-1:LANES*LANE_W] == $past(dest_i[DATA_W-1:LANES*LANE_W])));

  for (genvar j = 0; j < LANES; j++) begin : g_lane_chk
    a_r5_lane_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && mode_i == 2'd2 && !lane_mask_i[j]) |=>
        (result_o[j*LANE_W +: LANE_W] == $past(dest_i[j*LANE_W +: LANE_W])));
  end
endmodule

// File: tb/tb_bitlut3_unit.sv
module tb_bitlut3_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [63:0] ra_i = '0, rb_i = '0, rc_i = '0, dest_i = '0;
  logic [7:0]  table_i = '0;
  logic [3:0]  lane_mask_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  bitlut3_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .ra_i(ra_i), .rb_i(rb_i), .rc_i(rc_i), .dest_i(dest_i),
    .table_i(table_i), .lane_mask_i(lane_mask_i),
    .valid_o(valid_o), .result_o(result_o)
  );

  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] c, input logic [63:0] d,
      input logic [7:0] t, input logic [3:0] mk);
    logic [63:0] r;
    logic [7:0]  pat;
    r = d;
    case (m)
      2'd0: for (int i = 0; i < 64; i++) r[i] = t[{d[i], a[i], b[i]}];
      2'd1: for (int i = 0; i < 64; i++) r[i] = c[{d[i], a[i], b[i]}];
      2'd2: begin
        for (int k = 0; k < 8; k++) pat[k] = t[{a[k], a[8+k], a[16+k]}];
        for (int j = 0; j < 4; j++) if (mk[j]) r[j*8 +: 8] = pat;
      end
      default: r = {63'd0, t[{d != 0, a != 0, b != 0}]};
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] m, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] c, input logic [63:0] d,
      input logic [7:0] t, input logic [3:0] mk);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = m; ra_i = a; rb_i = b; rc_i = c; dest_i = d;
    table_i = t; lane_mask_i = mk;
    @(negedge clk_i);
    check({req, " result"}, result_o, model(m, a, b, c, d, t, mk));
    check("R7 valid", {63'd0, valid_o}, 64'd1);
    valid_i = 1'b0;
  endtask

  initial begin
    logic [63:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check("R9 valid_o reset", {63'd0, valid_o}, 64'd0);
    check("R9 result_o reset", result_o, 64'd0);
    rst_ni = 1'b1;

    // R1 one-hot tables probe index order
    for (int k = 0; k < 8; k++)
      run_op("R1", 2'd0, 64'hF0F0_F0F0_CCCC_3333, 64'hAAAA_5555_AAAA_0F0F,
             64'd0, 64'hFF00_FF00_1234_8765, 8'(1 << k), 4'd0);
    // R2 identities
    run_op("R2", 2'd0, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'd0,
           64'hDEAD_BEEF_0BAD_F00D, 8'hF0, 4'd0);
    check("R2 passthrough", result_o, 64'hDEAD_BEEF_0BAD_F00D);
    run_op("R2", 2'd0, 64'hFFFF_0000_FFFF_0000, 64'h1357_9BDF_2468_ACE0, 64'd0,
           64'h00FF_00FF_F0F0_0F0F, 8'hCA, 4'd0);
    check("R2 select", result_o,
          (64'h00FF_00FF_F0F0_0F0F & 64'hFFFF_0000_FFFF_0000) |
          (~64'h00FF_00FF_F0F0_0F0F & 64'h1357_9BDF_2468_ACE0));
    // R3 noise above rc bit 7
    run_op("R3", 2'd1, 64'hCAFE_BABE_0000_FFFF, 64'h0123_4567_89AB_CDEF,
           64'hFFFF_FFFF_FFFF_FF96, 64'h5A5A_A5A5_0F0F_F0F0, 8'h00, 4'd0);
    run_op("R3", 2'd1, 64'hCAFE_BABE_0000_FFFF, 64'h0123_4567_89AB_CDEF,
           64'h0000_0000_0000_0096, 64'h5A5A_A5A5_0F0F_F0F0, 8'hFF, 4'd0);
    // R4 R5 lane form, garbage in upper ra bits and rb
    run_op("R4", 2'd2, 64'hFFFF_FFFF_FF33_0FAA, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0,
           64'h1111_2222_3333_4444, 8'hE8, 4'hF);
    run_op("R5", 2'd2, 64'h8000_0000_00F0_CC5A, 64'd0, 64'd0,
           64'h1111_2222_3333_4444, 8'h01, 4'h0);
    check("R5 mask zero keeps dest", result_o, 64'h1111_2222_3333_4444);
    run_op("R5", 2'd2, 64'h0000_0000_0081_4224, 64'd7, 64'd0,
           64'hAAAA_BBBB_CCCC_DDDD, 8'h96, 4'b0101);
    // R6 whole-word form
    run_op("R6", 2'd3, 64'h8000_0000_0000_0000, 64'd0, 64'd0, 64'd0, 8'h04, 4'd0);
    check("R6 far bit", result_o, 64'd1);
    run_op("R6", 2'd3, 64'd0, 64'd0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hEF, 4'd0);
    check("R6 zero flag", result_o, 64'd0);

    // R8 idle with changing inputs
    held = result_o;
    @(negedge clk_i);
    mode_i = 2'd0; table_i = 8'hFF; ra_i = '1; dest_i = 64'h77; rc_i = '1;
    @(negedge clk_i);
    check("R8 hold", result_o, held);
    check("R7 valid low", {63'd0, valid_o}, 64'd0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [63:0] a, b, c, d;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      c = {$urandom, $urandom}; d = {$urandom, $urandom};
      if (n % 7 == 0) a = '0;
      if (n % 11 == 0) b = '0;
      if (n % 13 == 0) d = '0;
      run_op("R1/R3/R4/R6 random", 2'($urandom), a, b, c, d, 8'($urandom), 4'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule